// File: doc/BRIEF.md
# Flash Write-Status Readback Generator

This block stands in the read data path of a small nonvolatile byte store. It reports how far an internal write has got. An idle block returns stored bytes. A program or erase start makes it busy for a programmable number of cycles. While it is busy, every read returns two status bits in place of data:

- Bit 7 is a polarity flag. During a program it is the inverse of bit 7 of the pending byte. During an erase it is zero.
- Bit 6 alternates on each successive read.

When the busy counter runs out, the block commits the result. A program writes the pending byte to its address. An erase sets every byte to all ones. The block then goes back to returning stored data.

Software polls in one of two ways. It can read until bit 7 matches the written value. Or it can read until bit 6 stops changing. The store is a small register array that is part of the block, and its depth is a parameter.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, busy_o is 0, rd_data_o is 0x00 and every stored byte is 0xFF.
- R2: A start accepted while idle, with busy_len_i = L, holds busy_o high for exactly L+1 cycles, beginning the cycle after the start edge. The result is committed at the edge where busy_o falls.
- R3: A read sampled while busy during a program returns the following for any address:
  - bit 7 is the inverse of bit 7 of the pending byte;
  - bits 5:0 are the present stored contents of the address read.
- R4: A read sampled while busy during an erase returns 0 in bit 7. Bits 5:0 are the stored contents of the address read.
- R5: Bit 6 of the reads sampled during one operation follows the pattern 0, 1, 0, 1, and so on. The first busy read returns 0. Each later busy read returns the opposite of the one before. Clock cycles without a read do not advance the pattern.
- R6: A read sampled while idle returns the whole stored byte. After a program this is the programmed byte. After an erase it is 0xFF.
- R7: A read sampled in the last busy cycle, when the counter is at zero, still returns status. The next read returns committed data.
- R8: Program and erase starts that arrive while busy are ignored. They change neither the busy duration, nor the pending operation, nor the stored contents.
- R9: If a program start and an erase start arrive in the same idle cycle, the erase is taken and the program is dropped.
- R10: rd_data_o is updated only at an edge where rd_en_i is high, one cycle after the strobe. At every other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | Start-program pulse |
| prog_addr_i | input | ADDR_W | Target address of the program |
| prog_data_i | input | DATA_W | Byte to be programmed |
| erase_start_i | input | 1 | Start-erase pulse (whole array) |
| busy_len_i | input | CNT_W | Busy counter load value; the operation lasts value+1 cycles |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Registered read data or status |
| busy_o | output | 1 | Internal operation in progress |

## Verification
A read strobe and the end of the operation can land in the same cycle. This happens when the read is sampled while the busy counter is at zero, which is the edge where the commit is written. The bench provokes this with a busy length of 3 and four reads back to back from the start. The fourth read meets the commit edge. It must still return status bits, with bit 6 at 1. The read directly after it must return the newly committed byte.

A second collision is a start that arrives during a running operation. This is judged from the remaining busy cycles and from the contents read afterwards.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } wop_e;
endpackage

// File: rtl/wstat_timer.sv
module wstat_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= len_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (clear_i) tog_q <= 1'b0;
    else if (step_i)  tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/wstat_array.sv
module wstat_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_i)                              mem_q[i] <= '1;
        else if (waddr_i == ADDR_W'(i))           mem_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import flash_wstat_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              erase_start_i,
  input  logic [CNT_W-1:0]  busy_len_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  localparam int POL_B = DATA_W - 1;
  localparam int TOG_B = DATA_W - 2;

  logic              busy, done, tog, accept;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] arr_rdata, rd_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  wop_e              op_q;

  assign accept = (prog_start_i || erase_start_i) && !busy;

  wstat_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(prog_start_i || erase_start_i),
    .len_i (busy_len_i), .busy_o(busy), .cnt_o(cnt), .done_o(done)
  );

  wstat_toggle toggle_i (
    .clk_i (clk_i), .rst_ni(rst_ni), .clear_i(accept),
    .step_i(rd_en_i && busy), .tog_o(tog)
  );

  wstat_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk_i  (clk_i), .rst_ni(rst_ni), .commit_i(done),
    .erase_i(op_q == OP_ERASE), .waddr_i(pend_addr_q), .wdata_i(pend_data_q),
    .raddr_i(rd_addr_i), .rdata_o(arr_rdata)
  );

  // erase wins when both starts coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q        <= OP_PROG;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (accept) begin
      op_q        <= erase_start_i ? OP_ERASE : OP_PROG;
      pend_addr_q <= prog_addr_i;
      pend_data_q <= prog_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      if (busy) begin
        rd_q        <= arr_rdata;
        rd_q[POL_B] <= (op_q == OP_PROG) ? ~pend_data_q[POL_B] : 1'b0;
        rd_q[TOG_B] <= tog;
      end else begin
        rd_q <= arr_rdata;
      end
    end
  end

  assign rd_data_o = rd_q;
  assign busy_o    = busy;
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_start_i,
  input logic              erase_start_i,
  input logic              rd_en_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              tog_i,
  input logic              erase_op_i,
  input logic [DATA_W-1:0] pend_data_i
);
  assert_busy_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(prog_start_i || erase_start_i));

  assert_prog_stat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_o && !erase_op_i) |=> rd_data_o[DATA_W-1] == ~$past(pend_data_i[DATA_W-1]));

  assert_erase_stat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_o && erase_op_i) |=> !rd_data_o[DATA_W-1]);

  assert_toggle_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_o) |=> tog_i != $past(tog_i));

  assert_toggle_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && busy_o) |=> $stable(tog_i));

  assert_ignore_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_i != '0) |=> busy_o && cnt_i == $past(cnt_i) - 1'b1);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind flash_wstat_gen flash_wstat_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prog_start_i (prog_start_i),
  .erase_start_i(erase_start_i),
  .rd_en_i      (rd_en_i),
  .busy_o       (busy_o),
  .rd_data_o    (rd_data_o),
  .cnt_i        (cnt),
  .tog_i        (tog),
  .erase_op_i   (op_q == flash_wstat_pkg::OP_ERASE),
  .pend_data_i  (pend_data_q)
);

// File: tb/flash_wstat_gen_tb_top.sv
`timescale 1ns/1ps
module flash_wstat_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prog_start_i = 1'b0;
  logic [3:0] prog_addr_i = '0;
  logic [7:0] prog_data_i = '0;
  logic       erase_start_i = 1'b0;
  logic [7:0] busy_len_i = '0;
  logic       rd_en_i = 1'b0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       busy_o;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_mem [16];
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  flash_wstat_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_start_i(prog_start_i),
    .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i),
    .erase_start_i(erase_start_i), .busy_len_i(busy_len_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // entered at a negedge; returns at the following negedge
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic start(input logic p, input logic e, input logic [3:0] a,
                       input logic [7:0] d, input logic [7:0] len);
    prog_start_i = p; erase_start_i = e; prog_addr_i = a; prog_data_i = d; busy_len_i = len;
    @(negedge clk_i);
    prog_start_i = 1'b0; erase_start_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v, last;
    int n;
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy", {7'd0, busy_o}, 8'h00);
    chk("R1 rd_data", rd_data_o, 8'h00);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); chk("R1 erased", v, 8'hFF);
    end

    // program sweep, L=3: four status reads, last meets commit edge (R7)
    for (int a = 0; a < 16; a++) begin
      d = 8'(a * 29 + 3);
      start(1'b1, 1'b0, 4'(a), d, 8'd3);
      for (int k = 0; k < 4; k++) begin
        logic [3:0] ra;
        ra = (k % 2 == 0) ? 4'(a) : 4'(a + 1);
        rd(ra, v);
        chk((k == 3) ? "R7 last-cycle status" : "R3 prog status", v,
            {~d[7], 1'(k % 2), exp_mem[ra][5:0]});
      end
      exp_mem[a] = d;
      chk("R2 busy fall", {7'd0, busy_o}, 8'h00);
      rd(4'(a), v); chk("R6 programmed", v, d);
      repeat (2) @(negedge clk_i);
      chk("R10 hold", rd_data_o, d);
    end

    // erase, L=2: three status reads
    start(1'b0, 1'b1, 4'd0, 8'h00, 8'd2);
    for (int k = 0; k < 3; k++) begin
      rd(4'(k), v);
      chk("R4 erase status", v, {1'b0, 1'(k % 2), exp_mem[k][5:0]});
    end
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'hFF;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); chk("R6 erased", v, 8'hFF);
    end

    // idle gaps and ignored starts, L=6
    start(1'b1, 1'b0, 4'd2, 8'h5A, 8'd6);
    rd(4'd2, v); chk("R5 first busy read", v, {1'b1, 1'b0, 6'h3F});
    prog_start_i = 1'b1; erase_start_i = 1'b1; prog_addr_i = 4'd9;
    prog_data_i = 8'h00; busy_len_i = 8'd1;
    @(negedge clk_i);
    prog_start_i = 1'b0; erase_start_i = 1'b0;
    @(negedge clk_i);
    rd(4'd2, v); chk("R5 no idle advance", v, {1'b1, 1'b1, 6'h3F});
    n = 0;
    while (busy_o && n < 50) begin
      @(negedge clk_i); n++;
    end
    chk("R8 duration kept", 8'(n), 8'd3);
    exp_mem[2] = 8'h5A;
    rd(4'd9, v); chk("R8 ignored program", v, 8'hFF);
    rd(4'd5, v); chk("R8 ignored erase", v, 8'hFF);
    rd(4'd2, v); chk("R6 programmed", v, 8'h5A);

    // L=0: busy exactly one cycle
    start(1'b1, 1'b0, 4'd7, 8'h12, 8'd0);
    chk("R2 one cycle busy", {7'd0, busy_o}, 8'h01);
    @(negedge clk_i);
    chk("R2 one cycle end", {7'd0, busy_o}, 8'h00);
    rd(4'd7, v); chk("R2 committed", v, 8'h12);

    // simultaneous starts: erase wins
    start(1'b1, 1'b1, 4'd3, 8'h00, 8'd1);
    rd(4'd3, v); chk("R9 erase status", v, {1'b0, 1'b0, 6'h3F});
    last = v;
    @(negedge clk_i);
    rd(4'd3, v); chk("R9 no program", v, 8'hFF);
    rd(4'd7, v); chk("R9 erased", v, 8'hFF);
    chk("R10 changed on read", {7'd0, (v != last)}, 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule